// File: doc/BRIEF.md
# Quad Double-Buffered Converter Code Register Bank

This block keeps the digital state of a four-channel, 16-bit voltage converter. Every channel owns two registers: a staging buffer that receives new codes, and an output register whose value drives the converter core. A host can stage new codes quietly and then apply them to all channels in one step. It can also write straight through to chosen output registers. Writes arrive as decoded commands from a serial front end. Each command carries a channel mask, a 16-bit word and a flag that picks "stage only" or "stage and apply".

A single select input sets two things: the level that reset drives the channels to (zero-scale or mid-scale) and how incoming words are coded (straight binary or two's complement). The output codes are always offset binary, so a two's-complement word has its top bit inverted before it is stored. A separate load pin is asynchronous to the system clock. It is synchronised, and its rising edge copies every staging buffer into its output register in one cycle. Per-channel power-down flags are set or cleared by mask commands and do not alter the stored codes.

Top module: `qdac_regbank`

## Requirements
- R1: While reset is in effect (rst_n low, and for two clock edges after it rises), every output code is 0x0000 when range_sel is 0 and 0x8000 when range_sel is 1, and every pd_flag bit is 0. Asserting rst_n low applies this level at once, without waiting for a clock edge.
- R2: A write with wr_apply=0 changes only the staging buffers of the masked channels (bit i of wr_mask selects channel i). The output codes are not changed.
- R3: A write with wr_apply=1 sets the output code of every masked channel on the next clock edge. Channels outside the mask keep their codes.
- R4: A rising edge on load_in copies all four staging buffers to their output codes on the third clock edge after the rise. Holding load_in high causes no further copy.
- R5: With range_sel=0 the stored code equals wr_data. With range_sel=1, bit 15 of wr_data is inverted before it is stored. For example, 0x0001 is stored as 0x8001 and 0xFFFF as 0x7FFF.
- R6: A pd_valid command sets pd_flag bit i to pd_on for every channel whose pd_mask bit i is 1. Other flags and all output codes are not changed.
- R7: When a write with wr_apply=1 and a load take effect on the same clock edge, the written channels take the new word and the other channels take their staging buffers.
- R8: Reset takes priority over a pending load. Asserting rst_n while a load rise is in flight leaves all codes at the reset level.
- R9: With no applying write and no load edge, every output code holds its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| range_sel | input | 1 | 0: zero-scale reset, binary coding; 1: mid-scale reset, two's-complement coding |
| wr_valid | input | 1 | Write command strobe, one cycle |
| wr_mask | input | 4 | Channel mask of the write, bit i = channel i |
| wr_data | input | 16 | Code carried by the write |
| wr_apply | input | 1 | 1: also update the output register at once |
| pd_valid | input | 1 | Power-down command strobe |
| pd_mask | input | 4 | Channels affected by the power-down command |
| pd_on | input | 1 | Value written to the masked power-down flags |
| load_in | input | 1 | Asynchronous load pin, rising edge applies all buffers |
| dac_code | output | 64 | Offset-binary output codes, channel i at bits 16*i+15 down to 16*i |
| pd_flag | output | 4 | Power-down flag per channel |

## Verification
Write and power-down commands are due on the first clock edge after the cycle they are driven in. A load edge lands on the third edge after load_in rises, because of two synchroniser stages and one edge-detect register. A falling rst_n acts at once, and release takes two edges. The bench drives inputs on falling clock edges, and a cycle-accurate reference model updates on every rising edge. Comparisons are made on the following falling edge, so each result is checked in the exact cycle it is due. The load latency is also probed one cycle early to confirm that nothing moves before that cycle.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned CH_DEF     = 4;
  localparam int unsigned CODE_W_DEF = 16;
  localparam int unsigned SYNC_DEF   = 2;

  typedef enum logic {
    CODING_BINARY = 1'b0,
    CODING_TWOS   = 1'b1
  } coding_e;
endpackage

// File: rtl/qdac_rst_sync.sv
module qdac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/qdac_load_edge.sv
module qdac_load_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_async,
  output logic load_rise
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0] pipe_q;
  logic [SYNC_STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[SYNC_STAGES-1:0], load_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign load_rise = pipe_q[LAST] & ~pipe_q[SYNC_STAGES];
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_level,
  input  logic         stage_en,
  input  logic         apply_en,
  input  logic [W-1:0] new_code,
  input  logic         load_en,
  input  logic         pd_we,
  input  logic         pd_val,
  output logic [W-1:0] code,
  output logic         pd
);
  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] out_q, out_d;
  logic         pd_q, pd_d;
  logic         out_upd;

  always_comb begin
    stage_d = stage_q;
    if (stage_en) begin
      stage_d = new_code;
    end
    out_d = out_q;
    if (apply_en) begin
      out_d = new_code;
    end else if (load_en) begin
      out_d = stage_q;
    end
    pd_d = pd_q;
    if (pd_we) begin
      pd_d = pd_val;
    end
    out_upd = apply_en | load_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= rst_level;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= rst_level;
    end else if (out_upd) begin
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b0;
    end else if (pd_we) begin
      pd_q <= pd_d;
    end
  end

  assign code = out_q;
  assign pd   = pd_q;
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
  import qdac_pkg::*;
#(
  parameter int unsigned NCH  = CH_DEF,
  parameter int unsigned W    = CODE_W_DEF,
  parameter int unsigned SYNC = SYNC_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           range_sel,
  input  logic           wr_valid,
  input  logic [NCH-1:0] wr_mask,
  input  logic [W-1:0]   wr_data,
  input  logic           wr_apply,
  input  logic           pd_valid,
  input  logic [NCH-1:0] pd_mask,
  input  logic           pd_on,
  input  logic           load_in,
  output logic [NCH*W-1:0] dac_code,
  output logic [NCH-1:0] pd_flag
);
  localparam logic [W-1:0] ZERO_SCALE = '0;
  localparam logic [W-1:0] MID_SCALE  = {1'b1, {(W-1){1'b0}}};

  coding_e      coding;
  logic         rst_q_n;
  logic         ld_rise;
  logic [W-1:0] rst_level;
  logic [W-1:0] conv_code;

  assign coding    = coding_e'(range_sel);
  assign rst_level = (coding == CODING_TWOS) ? MID_SCALE : ZERO_SCALE;
  assign conv_code = (coding == CODING_TWOS) ? {~wr_data[W-1], wr_data[W-2:0]} : wr_data;

  qdac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_q_n)
  );

  qdac_load_edge #(.SYNC_STAGES(SYNC)) u_load (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .load_async (load_in),
    .load_rise  (ld_rise)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_wr;
    assign sel_wr = wr_valid & wr_mask[i];

    qdac_channel #(.W(W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .rst_level (rst_level),
      .stage_en  (sel_wr),
      .apply_en  (sel_wr & wr_apply),
      .new_code  (conv_code),
      .load_en   (ld_rise),
      .pd_we     (pd_valid & pd_mask[i]),
      .pd_val    (pd_on),
      .code      (dac_code[i*W +: W]),
      .pd        (pd_flag[i])
    );
  end
endmodule

// File: rtl/qdac_regbank_chk.sv
module qdac_regbank_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned W   = 16
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             ld_rise,
  input logic             range_sel,
  input logic             wr_valid,
  input logic [NCH-1:0]   wr_mask,
  input logic [W-1:0]     wr_data,
  input logic             wr_apply,
  input logic             pd_valid,
  input logic [NCH-1:0]   pd_mask,
  input logic             pd_on,
  input logic [NCH*W-1:0] dac_code,
  input logic [NCH-1:0]   pd_flag
);
  // R4
  load_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_rise |=> !ld_rise);

  // R1
  reset_flags_chk: assert property (@(posedge clk)
    !rst_q_n |-> pd_flag == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R1
    reset_level_chk: assert property (@(posedge clk)
      !rst_q_n |-> dac_code[i*W +: W] == {range_sel, {(W-1){1'b0}}});

    // R3
    apply_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      wr_valid && wr_apply && wr_mask[i] |=>
        dac_code[i*W +: W] == {$past(wr_data[W-1] ^ range_sel), $past(wr_data[W-2:0])});

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      !(wr_valid && wr_apply && wr_mask[i]) && !ld_rise |=> $stable(dac_code[i*W +: W]));

    // R6
    pd_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      pd_valid && pd_mask[i] |=> pd_flag[i] == $past(pd_on));

    // R6
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      !(pd_valid && pd_mask[i]) |=> $stable(pd_flag[i]));
  end
endmodule

bind qdac_regbank qdac_regbank_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .ld_rise   (ld_rise),
  .range_sel (range_sel),
  .wr_valid  (wr_valid),
  .wr_mask   (wr_mask),
  .wr_data   (wr_data),
  .wr_apply  (wr_apply),
  .pd_valid  (pd_valid),
  .pd_mask   (pd_mask),
  .pd_on     (pd_on),
  .dac_code  (dac_code),
  .pd_flag   (pd_flag)
);

// File: tb/qdac_regbank_tb.sv
module qdac_regbank_tb;
  localparam int NCH = 4;
  localparam int W   = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           range_sel;
  logic           wr_valid;
  logic [NCH-1:0] wr_mask;
  logic [W-1:0]   wr_data;
  logic           wr_apply;
  logic           pd_valid;
  logic [NCH-1:0] pd_mask;
  logic           pd_on;
  logic           load_in;
  logic [NCH*W-1:0] dac_code;
  logic [NCH-1:0] pd_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [W-1:0]   m_buf [NCH];
  logic [W-1:0]   m_out [NCH];
  logic [NCH-1:0] m_pd;
  logic           m_r1, m_r2;
  logic [2:0]     m_s;

  always #5 clk = ~clk;

  qdac_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .range_sel(range_sel),
    .wr_valid(wr_valid), .wr_mask(wr_mask), .wr_data(wr_data), .wr_apply(wr_apply),
    .pd_valid(pd_valid), .pd_mask(pd_mask), .pd_on(pd_on),
    .load_in(load_in), .dac_code(dac_code), .pd_flag(pd_flag)
  );

  function automatic logic [W-1:0] conv(input logic [W-1:0] d, input logic twos);
    return twos ? {~d[W-1], d[W-2:0]} : d;
  endfunction

  function automatic logic [W-1:0] level(input logic twos);
    return twos ? 16'h8000 : 16'h0000;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_buf[i] = level(range_sel);
      m_out[i] = level(range_sel);
    end
    m_pd = '0;
    m_s  = '0;
  endtask

  // reference model, built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
      m_r1 = 1'b0;
      m_r2 = 1'b0;
    end else if (!m_r2) begin
      model_reset();
      m_r2 = m_r1;
      m_r1 = 1'b1;
    end else begin
      logic rise;
      rise = m_s[1] & ~m_s[2];
      m_s  = {m_s[1:0], load_in};
      for (int i = 0; i < NCH; i++) begin
        logic [W-1:0] nxt;
        nxt = m_out[i];
        if (rise) nxt = m_buf[i];
        if (wr_valid && wr_mask[i]) begin
          if (wr_apply) nxt = conv(wr_data, range_sel);
          m_buf[i] = conv(wr_data, range_sel);
        end
        m_out[i] = nxt;
        if (pd_valid && pd_mask[i]) m_pd[i] = pd_on;
      end
    end
  end

  task automatic check_all(input string tag);
    bit ok;
    ok = 1'b1;
    total++;
    for (int i = 0; i < NCH; i++) begin
      if (dac_code[i*W +: W] !== m_out[i]) begin
        $display("FAIL %s ch%0d code actual=%h expected=%h", tag, i, dac_code[i*W +: W], m_out[i]);
        ok = 1'b0;
      end
    end
    if (pd_flag !== m_pd) begin
      $display("FAIL %s pd_flag actual=%b expected=%b", tag, pd_flag, m_pd);
      ok = 1'b0;
    end
    if (!ok) bad++;
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [NCH-1:0] m, input logic [W-1:0] d, input logic ap);
    wr_valid = 1'b1; wr_mask = m; wr_data = d; wr_apply = ap;
    tick();
    wr_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; range_sel = 1'b0; wr_valid = 1'b0; wr_mask = '0; wr_data = '0;
    wr_apply = 1'b0; pd_valid = 1'b0; pd_mask = '0; pd_on = 1'b0; load_in = 1'b0;
    #2 rst_n = 1'b0;
    tick(3);
    check_all("R1 zero-scale in reset");
    rst_n = 1'b1;
    tick(2);
    check_all("R1 level held through release");

    wr(4'b0001, 16'h1234, 1'b1);
    check_all("R3 R5 apply write binary");
    wr(4'b0010, 16'hABCD, 1'b0);
    check_all("R2 staged write leaves output");

    load_in = 1'b1;
    tick(2);
    check_all("R4 no copy before third edge");
    tick();
    check_all("R4 load copies buffers");
    wr(4'b0010, 16'h5555, 1'b0);
    tick(4);
    check_all("R4 held level gives no reload");
    load_in = 1'b0;
    tick(3);

    pd_valid = 1'b1; pd_mask = 4'b0101; pd_on = 1'b1;
    tick();
    pd_valid = 1'b0;
    check_all("R6 power-down mask");
    pd_valid = 1'b1; pd_mask = 4'b0001; pd_on = 1'b0;
    tick();
    pd_valid = 1'b0;
    check_all("R6 power-up one channel");

    wr(4'b0100, 16'h2222, 1'b0);
    load_in = 1'b1;
    tick(2);
    wr(4'b1000, 16'h0F0F, 1'b1);
    check_all("R7 apply write beats load on its channel");
    load_in = 1'b0;
    tick(3);

    range_sel = 1'b1;
    load_in = 1'b1;
    tick(2);
    rst_n = 1'b0;
    #1;
    check_all("R8 reset over pending load");
    @(negedge clk);
    check_all("R1 mid-scale in reset");
    rst_n = 1'b1;
    tick(3);
    load_in = 1'b0;
    tick(3);
    check_all("R1 mid-scale after release");

    wr(4'b1111, 16'h0001, 1'b1);
    check_all("R5 twos 0x0001");
    wr(4'b0100, 16'hFFFF, 1'b1);
    check_all("R5 twos 0xFFFF");

    void'($urandom(32'd1357));
    for (int k = 0; k < 4000; k++) begin
      wr_valid  = ($urandom % 3) == 0;
      wr_mask   = NCH'($urandom);
      wr_data   = W'($urandom);
      wr_apply  = $urandom % 2;
      pd_valid  = ($urandom % 5) == 0;
      pd_mask   = NCH'($urandom);
      pd_on     = $urandom % 2;
      if (($urandom % 4) == 0) load_in = ~load_in;
      if (($urandom % 50) == 0) range_sel = ~range_sel;
      tick();
      check_all("R9 random traffic");
    end
    wr_valid = 1'b0; pd_valid = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule